// File: doc/BRIEF.md
# Complementary Gate-Drive Dead-Band Generator with Fault Latch

This block takes one PWM signal per motor phase and turns it into a high-side and low-side gate-drive pair. In dead-band mode, every PWM transition switches off the transistor that is conducting. The complementary transistor is switched on only after a programmable gap has elapsed. The gap is timed by a 16-bit reloadable down-counter per phase. That counter advances on a shared prescaled tick, and its underflow marks the end of the gap and can raise an interrupt. Each pair can be inverted, and each phase can be put in a plain pass-through mode instead.

A shutdown path guards the bridge. The sources are an active-low fault pin and a software fault bit, which are combined by OR. The pin can be passed through a glitch filter of selectable length. Once a fault is recognised, all six drive outputs switch to safe levels loaded beforehand. They stay there until the fault source has gone away and software acknowledges the fault. A simple register port (write strobe, address, write data, combinational read data) configures the block. The PWM signals come from elsewhere.

Top module: `deadband_fault_gen`

## Requirements
- R1: With phase-control bits [2:0] (address 4+p) equal to 100, a change on pwm_in[p] switches both drive outputs of pair p off at the next clock edge. The side selected by the new PWM level (high when 1, low when 0) turns on after reload+1 prescaler ticks, where reload is held at address 8+p. Both sides are never on together.
- R2: At the end of each gap, status bit 2+p (address 1) is set. irq_dt is the OR over phases of that bit ANDed with phase-control bit 4. Writing 1 to status bit 2+p clears it.
- R3: If the PWM level of a phase returns before its gap ends, the gap restarts. The side that would have turned on gives no pulse at all.
- R4: Any mode value other than 100 gives pass-through: one clock after the PWM level is sampled, the high side equals it and the low side equals its complement.
- R5: Phase-control bit 3 inverts both outputs of its pair.
- R6: Control bits [6:4] (address 0) choose sel, and the dead-band counters then advance once every 2^sel clocks.
- R7: The fault source is the low level on flt_n, ORed with the software bit (address 2, bit 0, which resets to 1; writing 0 asserts a fault and writing 1 releases it). The source has effect only while control bit 0 is 1.
- R8: When control bit 1 is 0, an active source is recognised at the first clock edge that samples it. When control bit 1 is 1, the source must be sampled active on 4·2^k+1 consecutive edges, where k is control bits [3:2]. Any inactive sample restarts the count.
- R9: While a fault is latched, drv_hi[p] equals bit 2p and drv_lo[p] equals bit 2p+1 of the safe register (address 3), whatever the PWM and inversion settings. Status bit 0 reads 1, and irq_flt equals status bit 0 ANDed with control bit 7.
- R10: A latched fault clears only when 1 is written to status bit 0 while the fault source is inactive. A write made while the source is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 3 | PWM level per phase |
| flt_n | input | 1 | Active-low fault pin, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| drv_hi | output | 3 | High-side drive per phase |
| drv_lo | output | 3 | Low-side drive per phase |
| irq_dt | output | 1 | Dead-band end interrupt |
| irq_flt | output | 1 | Fault interrupt |

## Verification
The hardest case to reach from the ports is a PWM pulse shorter than the gap, because the level has to flip back while the counter is still running. The bench flips phase 0 twice inside a four-tick gap and watches the low side on every cycle of the window. Prescaled timing is also awkward, since the free-running prescaler phase is unknown at the PWM edge. That case is checked against the earliest and latest possible turn-on edges. The filter's counter restart is reached by a low run one sample short, followed by a single high sample and another short low run.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam logic [2:0] MODE_DEADBAND = 3'b100;
  localparam int ADDR_GCTRL  = 0;
  localparam int ADDR_STAT   = 1;
  localparam int ADDR_SWFLT  = 2;
  localparam int ADDR_SAFE   = 3;
  localparam int ADDR_PHC    = 4;
  localparam int ADDR_RELOAD = 8;
  localparam int PSW    = 8;
  localparam int FLT_CW = 6;

  // number of consecutive active samples that must precede recognition
  function automatic logic [FLT_CW-1:0] filt_len(input logic [1:0] k);
    return FLT_CW'(4) << k;
  endfunction

  // prescaler fires when the low sel bits of the free-running count are all ones
  function automatic logic prescale_hit(input logic [PSW-1:0] cnt, input logic [2:0] sel);
    logic [PSW-1:0] mask;
    mask = (PSW'(1) << sel) - PSW'(1);
    return (cnt & mask) == mask;
  endfunction
endpackage

// File: rtl/dbf_prescaler.sv
module dbf_prescaler
  import dbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PSW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick = prescale_hit(cnt, sel);

  // R6: with the fastest setting a tick occurs on every clock
  assert_tick_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && $past(sel) == 3'd0) |-> (tick && $past(tick)));
endmodule

// File: rtl/dbf_phase.sv
module dbf_phase #(
  parameter int DTW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           pwm,
  input  logic           mode_db,
  input  logic [DTW-1:0] reload,
  output logic           hi_q,
  output logic           lo_q,
  output logic           uf
);
  logic           pwm_last;
  logic           waiting;
  logic [DTW-1:0] cnt;

  assign uf = mode_db & waiting & tick & (cnt == '0) & (pwm == pwm_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_last <= 1'b0;
      waiting  <= 1'b0;
      cnt      <= '0;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
    end else if (!mode_db) begin
      pwm_last <= pwm;
      waiting  <= 1'b0;
      cnt      <= '0;
      hi_q     <= pwm;
      lo_q     <= ~pwm;
    end else if (pwm != pwm_last) begin
      pwm_last <= pwm;
      waiting  <= 1'b1;
      cnt      <= reload;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
    end else if (uf) begin
      waiting  <= 1'b0;
      hi_q     <= pwm_last;
      lo_q     <= ~pwm_last;
    end else if (waiting && tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R1: in dead-band mode a side only turns on after the other side was off
  assert_gap_before_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_q) && $past(mode_db)) |-> !$past(lo_q));
  assert_gap_before_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_q) && $past(mode_db)) |-> !$past(hi_q));
  // R2: an underflow ends the gap with exactly one side on
  assert_uf_turnon_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (hi_q != lo_q));
endmodule

// File: rtl/dbf_fault.sv
module dbf_fault
  import dbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic       sw_n,
  input  logic       enable,
  input  logic       filt_en,
  input  logic [1:0] filt_k,
  input  logic       clr_req,
  output logic       latched,
  output logic       raw
);
  logic [FLT_CW-1:0] run;
  logic              detect;

  assign raw    = enable & (~pin_n | ~sw_n);
  assign detect = raw & (~filt_en | (run >= filt_len(filt_k)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      latched <= 1'b0;
    end else begin
      if (!raw)           run <= '0;
      else if (run != '1) run <= run + 1'b1;
      if (detect)                latched <= 1'b1;
      else if (clr_req && !raw)  latched <= 1'b0;
    end
  end

  // R10: an active source keeps the latch set
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && raw) |=> latched);
  // R7: the latch only sets from an enabled, active source
  assert_latch_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> $past(raw));
  // R8: with the shortest filter, five active samples precede recognition
  assert_filter_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latched) && $past(filt_en) && $past(filt_k) == 2'd0 && $past(filt_en, 5))
      |-> ($past(raw, 2) && $past(raw, 3) && $past(raw, 4) && $past(raw, 5)));
endmodule

// File: rtl/deadband_fault_gen.sv
module deadband_fault_gen
  import dbf_pkg::*;
#(
  parameter int NPH = 3,
  parameter int DTW = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] pwm_in,
  input  logic           flt_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DTW-1:0] bus_wdata,
  output logic [DTW-1:0] bus_rdata,
  output logic [NPH-1:0] drv_hi,
  output logic [NPH-1:0] drv_lo,
  output logic           irq_dt,
  output logic           irq_flt
);
  localparam int SAFE_W = 2 * NPH;

  logic [7:0]        gctrl;
  logic              sw_n_q;
  logic [SAFE_W-1:0] safe_q;
  logic [2:0]        ph_mode [NPH];
  logic [NPH-1:0]    ph_inv;
  logic [NPH-1:0]    ph_ie;
  logic [DTW-1:0]    reload [NPH];
  logic [NPH-1:0]    uf_flag;

  logic              tick;
  logic [NPH-1:0]    ph_hi, ph_lo, uf_vec;
  logic              shutdown, flt_raw;
  logic              stat_wr;

  assign stat_wr = bus_wr && (bus_addr == AW'(ADDR_STAT));

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctrl  <= '0;
      sw_n_q <= 1'b1;
      safe_q <= '0;
      ph_inv <= '0;
      ph_ie  <= '0;
      for (int p = 0; p < NPH; p++) begin
        ph_mode[p] <= '0;
        reload[p]  <= '0;
      end
    end else if (bus_wr) begin
      if (bus_addr == AW'(ADDR_GCTRL)) gctrl  <= bus_wdata[7:0];
      if (bus_addr == AW'(ADDR_SWFLT)) sw_n_q <= bus_wdata[0];
      if (bus_addr == AW'(ADDR_SAFE))  safe_q <= bus_wdata[SAFE_W-1:0];
      for (int p = 0; p < NPH; p++) begin
        if (bus_addr == AW'(ADDR_PHC + p)) begin
          ph_mode[p] <= bus_wdata[2:0];
          ph_inv[p]  <= bus_wdata[3];
          ph_ie[p]   <= bus_wdata[4];
        end
        if (bus_addr == AW'(ADDR_RELOAD + p)) reload[p] <= bus_wdata;
      end
    end
  end

  // gap-end flags: set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_flag <= '0;
    else begin
      for (int p = 0; p < NPH; p++) begin
        if (uf_vec[p])                       uf_flag[p] <= 1'b1;
        else if (stat_wr && bus_wdata[2+p])  uf_flag[p] <= 1'b0;
      end
    end
  end

  dbf_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (gctrl[6:4]),
    .tick  (tick)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    dbf_phase #(.DTW(DTW)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .pwm     (pwm_in[g]),
      .mode_db (ph_mode[g] == MODE_DEADBAND),
      .reload  (reload[g]),
      .hi_q    (ph_hi[g]),
      .lo_q    (ph_lo[g]),
      .uf      (uf_vec[g])
    );
    assign drv_hi[g] = shutdown ? safe_q[2*g]   : (ph_hi[g] ^ ph_inv[g]);
    assign drv_lo[g] = shutdown ? safe_q[2*g+1] : (ph_lo[g] ^ ph_inv[g]);
  end

  dbf_fault u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (flt_n),
    .sw_n    (sw_n_q),
    .enable  (gctrl[0]),
    .filt_en (gctrl[1]),
    .filt_k  (gctrl[3:2]),
    .clr_req (stat_wr && bus_wdata[0]),
    .latched (shutdown),
    .raw     (flt_raw)
  );

  assign irq_dt  = |(uf_flag & ph_ie);
  assign irq_flt = shutdown & gctrl[7];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_GCTRL)) bus_rdata = DTW'(gctrl);
    if (bus_addr == AW'(ADDR_STAT))  bus_rdata = DTW'({uf_flag, flt_raw, shutdown});
    if (bus_addr == AW'(ADDR_SWFLT)) bus_rdata = DTW'(sw_n_q);
    if (bus_addr == AW'(ADDR_SAFE))  bus_rdata = DTW'(safe_q);
    for (int p = 0; p < NPH; p++) begin
      if (bus_addr == AW'(ADDR_PHC + p))    bus_rdata = DTW'({ph_ie[p], ph_inv[p], ph_mode[p]});
      if (bus_addr == AW'(ADDR_RELOAD + p)) bus_rdata = reload[p];
    end
  end

  // R9: while shut down with a fixed safe pattern the drive pins do not move
  assert_frozen_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && $past(shutdown) && $stable(safe_q)) |-> ($stable(drv_hi) && $stable(drv_lo)));
  // R2: the gap-end interrupt rises only after a gap has ended
  assert_irq_dt_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_dt) && !$past(bus_wr)) |-> $past(|uf_vec));
endmodule

// File: tb/sim_deadband_fault_gen.sv
module sim_deadband_fault_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pwm = 3'b000;
  logic        flt_n = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [2:0]  drv_hi, drv_lo;
  logic        irq_dt, irq_flt;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  deadband_fault_gen u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .flt_n(flt_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .irq_dt(irq_dt), .irq_flt(irq_flt)
  );

  // vector: [6:4] mode, [3] invert, [2] pwm, [1] expected high, [0] expected low
  localparam logic [6:0] VEC [8] = '{
    7'b000_0_1_10, 7'b000_0_0_01, 7'b000_1_1_01, 7'b000_1_0_10,
    7'b100_0_1_10, 7'b100_1_0_10, 7'b001_0_1_10, 7'b110_1_1_01
  };

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic clear_fault();
    wr(4'd1, 16'h0001);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int lo_seen;
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state
    chk("reset drv_hi", {29'd0, drv_hi}, 32'd0);
    chk("reset irq", {30'd0, irq_dt, irq_flt}, 32'd0);
    rd(4'd2, r);
    chk("R7 reset software fault bit", {16'd0, r}, 32'd1);

    // table walk over modes and inversion on all phases
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 3; p++) wr(4'(4 + p), {12'd0, VEC[i][3], VEC[i][6:4]});
      pwm = {3{VEC[i][2]}};
      step(8);
      chk($sformatf("R4/R5 vec%0d high", i), {29'd0, drv_hi}, {29'd0, {3{VEC[i][1]}}});
      chk($sformatf("R4/R5 vec%0d low", i),  {29'd0, drv_lo}, {29'd0, {3{VEC[i][0]}}});
    end
    wr(4'd5, 16'h0000);
    wr(4'd6, 16'h0000);
    pwm = 3'b000;

    // R1 dead-band timing on phase 0, reload 3, every-clock tick
    wr(4'd8, 16'd3);
    wr(4'd4, 16'h0014);
    step(8);
    chk("R1 settled low side", {31'd0, drv_lo[0]}, 32'd1);
    wr(4'd1, 16'h001C);
    pwm[0] = 1'b1;
    step(1);
    chk("R1 both off after edge", {30'd0, drv_hi[0], drv_lo[0]}, 32'd0);
    step(3);
    chk("R1 still off at reload edges", {30'd0, drv_hi[0], drv_lo[0]}, 32'd0);
    step(1);
    chk("R1 high on after reload+1", {30'd0, drv_hi[0], drv_lo[0]}, 32'b10);
    chk("R2 irq_dt raised", {31'd0, irq_dt}, 32'd1);
    rd(4'd1, r);
    chk("R2 status bit2", {31'd0, r[2]}, 32'd1);
    wr(4'd1, 16'h0004);
    chk("R2 irq_dt cleared", {31'd0, irq_dt}, 32'd0);

    // R3 pulse shorter than the gap
    lo_seen = 0;
    pwm[0] = 1'b0;
    for (int c = 0; c < 3; c++) begin step(1); if (drv_lo[0]) lo_seen++; end
    pwm[0] = 1'b1;
    for (int c = 0; c < 6; c++) begin step(1); if (drv_lo[0]) lo_seen++; end
    chk("R3 no low pulse", lo_seen, 32'd0);
    chk("R3 high returns", {31'd0, drv_hi[0]}, 32'd1);

    // R6 prescaler every 4 clocks
    wr(4'd0, 16'h0020);
    pwm[0] = 1'b0;
    step(12);
    chk("R6 low still off", {31'd0, drv_lo[0]}, 32'd0);
    step(5);
    chk("R6 low on by latest tick", {31'd0, drv_lo[0]}, 32'd1);
    wr(4'd0, 16'h0000);

    // safe pattern: hi=101, lo=010
    wr(4'd3, 16'h0019);
    // R7 fault ignored when disabled
    flt_n = 1'b0;
    step(3);
    chk("R7 disabled fault high", {29'd0, drv_hi}, 32'd0);
    chk("R7 disabled fault low", {29'd0, drv_lo}, 32'h7);
    flt_n = 1'b1;

    // R9 immediate shutdown
    wr(4'd0, 16'h0081);
    flt_n = 1'b0;
    step(1);
    chk("R9 safe high", {29'd0, drv_hi}, 32'h5);
    chk("R9 safe low", {29'd0, drv_lo}, 32'h2);
    chk("R9 irq_flt", {31'd0, irq_flt}, 32'd1);
    pwm = 3'b111;
    step(3);
    chk("R9 pwm ignored", {26'd0, drv_hi, drv_lo}, 32'h2A);
    rd(4'd1, r);
    chk("R9 status bit0", {31'd0, r[0]}, 32'd1);
    pwm = 3'b000;
    flt_n = 1'b1;
    step(2);
    chk("R10 latched after release", {29'd0, drv_hi}, 32'h5);
    flt_n = 1'b0;
    clear_fault();
    step(1);
    chk("R10 clear ignored while active", {29'd0, drv_hi}, 32'h5);
    flt_n = 1'b1;
    clear_fault();
    step(6);
    chk("R10 normal high after clear", {29'd0, drv_hi}, 32'd0);
    chk("R10 normal low after clear", {29'd0, drv_lo}, 32'h7);

    // R7 software fault
    wr(4'd2, 16'h0000);
    step(1);
    chk("R7 software fault shutdown", {31'd0, irq_flt}, 32'd1);
    wr(4'd2, 16'h0001);
    clear_fault();
    step(1);
    chk("R7 software release", {31'd0, irq_flt}, 32'd0);

    // R8 filter k=1 -> 9 samples
    wr(4'd0, 16'h0087);
    flt_n = 1'b0;
    step(8);
    chk("R8 k1 not yet", {31'd0, irq_flt}, 32'd0);
    step(1);
    chk("R8 k1 recognised", {31'd0, irq_flt}, 32'd1);
    flt_n = 1'b1;
    clear_fault();
    // R8 restart on a high sample, k=0 -> 5 samples
    wr(4'd0, 16'h0083);
    flt_n = 1'b0; step(4);
    flt_n = 1'b1; step(1);
    flt_n = 1'b0; step(4);
    chk("R8 glitch restarts count", {31'd0, irq_flt}, 32'd0);
    step(1);
    chk("R8 k0 recognised", {31'd0, irq_flt}, 32'd1);
    flt_n = 1'b1;
    clear_fault();
    step(1);
    chk("R10 final clear", {31'd0, irq_flt}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule